// File: doc/BRIEF.md
# Handshake-Stepped Four-Rail Power Sequencer

This block switches four supply rails on and off in a fixed order. Each rail is controlled by a gate-enable output that drives an external switch. The sequencer moves from one rail to the next when that switch reports its state through a digital flag. It does not use delay timers between rails. Comparators outside the block watch each gate voltage and report two flags per rail. One flag says the gate is near full drive, and the other says the gate is discharged. Four under-voltage-OK flags and an active-low enable are filtered against glitches before the block acts on them.

Power-up starts when all rails are healthy and enable has been held for a stabilisation window. The gates then come on A, B, C, D. A reset-done output releases a fixed delay after the last gate reports full drive. Releasing enable turns the gates off in the exact reverse order. A rail that loses its under-voltage flag is a fault, and so is a handshake that never arrives. On a fault, all gates drop together, a one-cycle fast-discharge strobe fires, and the system-reset line is pulled. Once the fault clears, the block restarts on its own.

Top module: `hs_rail_sequencer`

## Requirements
- R1: Gate bit 0 is rail A and bit 3 is rail D. During power-up, gate_en only steps through 0000, 0001, 0011, 0111, 1111. During a turn-off started by enable, it only steps down through the same masks in reverse, so D goes off first and A last.
- R2: gates stay off while any filtered under-voltage flag or the filtered enable is missing. Gate A rises exactly FILT_CYC+STAB_CYC+1 clock edges after the last qualifying input settles. If an input drops during the stabilisation wait, the block returns to idle without raising a fault, and the full wait starts again.
- R3: during power-up, gate k+1 rises on the first clock edge that samples near_hi[k] high.
- R4: when enable is released from the fully-on state, gate D drops FILT_CYC+1 edges later. Each next lower gate then drops on the first edge that samples gate_low of the gate above it high.
- R5: rst_done_n goes high DONE_CYC+1 edges after near_hi[3] is first driven high. It goes low again on the same edge that starts a turn-off.
- R6: when a filtered under-voltage flag drops while any gate is sequencing, all gates go off together FILT_CYC+1 edges after the drop. On that cycle fast_off is high for exactly one cycle, sys_rst_pull goes high, and rst_done_n is low.
- R7: sys_rst_pull stays high while any filtered under-voltage flag is missing or any gate_low flag is low. It clears FILT_CYC+1 edges after the last missing rail returns. With enable still asserted, gate A then rises FILT_CYC+STAB_CYC+2 edges after that return, with no outside action.
- R8: if the flag a step waits for does not arrive within HS_TMO_CYC edges of that step starting, the block handles it exactly like an R6 fault.
- R9: an under-voltage or enable pulse shorter than FILT_CYC cycles has no effect on any output.
- R10: during reset all gates are off, and fast_off, sys_rst_pull and rst_done_n are low.
- R11: enable released in mid power-up begins the turn-off at the highest gate then on. That gate drops FILT_CYC+1 edges after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_ok | input | N_CH | Per-rail input above its under-voltage threshold |
| en_n | input | 1 | Active-low sequencing enable |
| near_hi | input | N_CH | Per-gate flag: gate within about 1 V of full drive |
| gate_low | input | N_CH | Per-gate flag: gate below about 0.6 V |
| gate_en | output | N_CH | Gate enable per rail, bit 0 = A |
| fast_off | output | 1 | One-cycle strobe for fast discharge of all gates on a fault |
| sys_rst_pull | output | 1 | High while the shared system-reset line must be pulled low |
| rst_done_n | output | 1 | Active-low reset: high once the full sequence has settled |

## Verification
The bench models the gate comparators. Each rail answers its gate enable after a random number of cycles. Runs with short and long response delays show whether stepping follows the flags or the elapsed time. Directed runs cover several cases:
- a fault from a missing rail, which shows the all-at-once shutdown apart from the ordered one;
- a frozen flag during power-up and during turn-off, which triggers the timeout path;
- enable released mid-ramp;
- a rail lost during the stabilisation wait;
- pulses one cycle short of the filter length, which show whether the filter's boundary is counted exactly.

// File: rtl/hs_rail_sequencer.sv
module hs_rail_sequencer #(
  parameter int N_CH       = 4,
  parameter int FILT_CYC   = 30,
  parameter int STAB_CYC   = 10000,
  parameter int DONE_CYC   = 160000,
  parameter int HS_TMO_CYC = 5000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] uv_ok,
  input  logic            en_n,
  input  logic [N_CH-1:0] near_hi,
  input  logic [N_CH-1:0] gate_low,
  output logic [N_CH-1:0] gate_en,
  output logic            fast_off,
  output logic            sys_rst_pull,
  output logic            rst_done_n
);
  localparam int NF    = N_CH + 1;
  localparam int FW    = $clog2(FILT_CYC + 1);
  localparam int CMAX0 = (STAB_CYC > DONE_CYC) ? STAB_CYC : DONE_CYC;
  localparam int CMAX  = (CMAX0 > HS_TMO_CYC) ? CMAX0 : HS_TMO_CYC;
  localparam int CW    = $clog2(CMAX + 1);
  localparam int IW    = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam logic [IW-1:0] LAST = IW'(N_CH - 1);

  typedef enum logic [2:0] {S_OFF, S_STAB, S_UP, S_HOLD, S_RUN, S_DOWN, S_FAULT} st_t;

  logic [NF-1:0] raw_in, filt;
  assign raw_in = {~en_n, uv_ok};

  for (genvar i = 0; i < NF; i++) begin : g_filt
    logic          q;
    logic [FW-1:0] c;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= 1'b0;
        c <= '0;
      end else if (raw_in[i] == q) begin
        c <= '0;
      end else if (c == FW'(FILT_CYC - 1)) begin
        q <= raw_in[i];
        c <= '0;
      end else begin
        c <= c + 1'b1;
      end
    end
    assign filt[i] = q;
  end

  logic uv_all, en_ok, go;
  assign uv_all = &filt[N_CH-1:0];
  assign en_ok  = filt[N_CH];
  assign go     = uv_all & en_ok;

  st_t           st, st_n;
  logic [IW-1:0] idx, idx_n;
  logic [CW-1:0] cnt;

  function automatic logic [N_CH-1:0] lowmask(input logic [IW:0] n);
    logic [N_CH:0] w;
    w = ({{N_CH{1'b0}}, 1'b1} << n) - 1'b1;
    return w[N_CH-1:0];
  endfunction

  always_comb begin
    st_n  = st;
    idx_n = idx;
    unique case (st)
      S_OFF:  if (go) st_n = S_STAB;
      S_STAB: begin
        if (!go) st_n = S_OFF;
        else if (cnt == CW'(STAB_CYC - 1)) begin
          st_n  = S_UP;
          idx_n = '0;
        end
      end
      S_UP: begin
        if (!uv_all) st_n = S_FAULT;
        else if (!en_ok) st_n = S_DOWN;
        else if (near_hi[idx]) begin
          if (idx == LAST) st_n = S_HOLD;
          else idx_n = idx + 1'b1;
        end else if (cnt == CW'(HS_TMO_CYC - 1)) st_n = S_FAULT;
      end
      S_HOLD, S_RUN: begin
        if (!uv_all) st_n = S_FAULT;
        else if (!en_ok) begin
          st_n  = S_DOWN;
          idx_n = LAST;
        end else if (st == S_HOLD && cnt == CW'(DONE_CYC - 1)) st_n = S_RUN;
      end
      S_DOWN: begin
        if (!uv_all) st_n = S_FAULT;
        else if (gate_low[idx]) begin
          if (idx == '0) st_n = S_OFF;
          else idx_n = idx - 1'b1;
        end else if (cnt == CW'(HS_TMO_CYC - 1)) st_n = S_FAULT;
      end
      S_FAULT: if (uv_all && (&gate_low)) st_n = S_OFF;
      default: st_n = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_OFF;
      idx      <= '0;
      cnt      <= '0;
      fast_off <= 1'b0;
    end else begin
      st       <= st_n;
      idx      <= idx_n;
      fast_off <= (st_n == S_FAULT) && (st != S_FAULT);
      if (st_n != st || idx_n != idx) cnt <= '0;
      else if (cnt != CW'(CMAX)) cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    unique case (st)
      S_UP:          gate_en = lowmask({1'b0, idx} + 1'b1);
      S_HOLD, S_RUN: gate_en = '1;
      S_DOWN:        gate_en = lowmask({1'b0, idx});
      default:       gate_en = '0;
    endcase
  end

  assign sys_rst_pull = (st == S_FAULT);
  assign rst_done_n   = (st == S_RUN);
endmodule

// File: rtl/hs_rail_sequencer_chk.sv
module hs_rail_sequencer_chk #(
  parameter int N_CH = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_CH-1:0] near_hi,
  input logic [N_CH-1:0] gate_low,
  input logic [N_CH-1:0] gate_en,
  input logic            fast_off,
  input logic            sys_rst_pull,
  input logic            rst_done_n
);
  for (genvar k = 0; k < N_CH - 1; k++) begin : g_step
    assert_step_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_en[k+1]) |-> $past(near_hi[k]));
    assert_step_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(gate_en[k]) && !fast_off && !$past(gate_en[k+1])) |-> $past(gate_low[k+1]));
  end

  assert_fault_all_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fast_off |-> (gate_en == '0 && sys_rst_pull && !rst_done_n));

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fast_off |=> !fast_off);

  assert_done_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_done_n) |-> (gate_en == '1));

  assert_pull_not_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pull |-> !rst_done_n);
endmodule

bind hs_rail_sequencer hs_rail_sequencer_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .near_hi(near_hi), .gate_low(gate_low),
  .gate_en(gate_en), .fast_off(fast_off), .sys_rst_pull(sys_rst_pull),
  .rst_done_n(rst_done_n)
);

// File: tb/hs_rail_sequencer_bench.sv
module hs_rail_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FILT = 6;
  localparam int STAB = 20;
  localparam int DONE = 30;
  localparam int TMO  = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] uv_ok = 4'h0;
  logic       en_n = 1'b1;
  logic [3:0] near_hi = 4'h0;
  logic [3:0] gate_low = 4'hF;
  logic [3:0] gate_en;
  logic       fast_off, sys_rst_pull, rst_done_n;

  hs_rail_sequencer #(.N_CH(4), .FILT_CYC(FILT), .STAB_CYC(STAB), .DONE_CYC(DONE),
                      .HS_TMO_CYC(TMO)) u_hs_rail_sequencer (
    .clk(clk), .rst_n(rst_n), .uv_ok(uv_ok), .en_n(en_n), .near_hi(near_hi),
    .gate_low(gate_low), .gate_en(gate_en), .fast_off(fast_off),
    .sys_rst_pull(sys_rst_pull), .rst_done_n(rst_done_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  int up_max = 8, dn_max = 8;
  logic [3:0] up_ok = 4'hF, dn_ok = 4'hF;
  int t_hi[4], t_lo[4];

  function automatic logic [3:0] prefix(input int n);
    if (n <= 0) return 4'h0;
    if (n >= 4) return 4'hF;
    return 4'((1 << n) - 1);
  endfunction
  function automatic int lat_start();   return FILT + STAB + 1; endfunction
  function automatic int lat_restart(); return FILT + STAB + 2; endfunction
  function automatic int lat_filt();    return FILT + 1;        endfunction

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // gate comparator model
  initial begin
    logic [3:0] prev;
    int uc[4];
    int dc[4];
    prev = 4'h0;
    for (int k = 0; k < 4; k++) begin uc[k] = 1; dc[k] = 1; end
    forever begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        if (gate_en[k] != prev[k]) begin
          uc[k] = $urandom_range(up_max, 1);
          dc[k] = $urandom_range(dn_max, 1);
        end
        if (gate_en[k]) begin
          gate_low[k] = 1'b0;
          if (!near_hi[k] && up_ok[k]) begin
            if (uc[k] <= 1) begin near_hi[k] = 1'b1; t_hi[k] = cyc; end
            else uc[k]--;
          end
        end else begin
          near_hi[k] = 1'b0;
          if (!gate_low[k] && dn_ok[k]) begin
            if (dc[k] <= 1) begin gate_low[k] = 1'b1; t_lo[k] = cyc; end
            else dc[k]--;
          end
        end
      end
      prev = gate_en;
    end
  end

  task automatic wait_for(input logic [3:0] v);
    int g;
    g = 0;
    while (gate_en !== v && g < 3000) begin tick(); g++; end
  endtask

  task automatic run_up(input int t0, input int exp_lat);
    int on, guard;
    on = 0; guard = 0;
    while (rst_done_n !== 1'b1 && guard < 3000) begin
      tick(); guard++;
      if (gate_en !== prefix(on)) begin
        check_eq("R1", "ramp-up order", gate_en, prefix(on + 1));
        if (on == 0) begin
          if (exp_lat > 0) check_eq("R2", "first gate latency", cyc - t0, exp_lat);
        end else check_eq("R3", "step after near-high flag", cyc - t_hi[on-1], 1);
        on++;
        if (on > 4) guard = 3000;
      end
    end
    check_eq("R5", "reset-done delay", cyc - t_hi[3], DONE + 1);
    check_eq("R1", "all gates on", gate_en, 4'hF);
  endtask

  task automatic run_down(input int t0, input string tag);
    int on, guard;
    bit first;
    on = $countones(gate_en); guard = 0; first = 1'b1;
    while (gate_en !== 4'h0 && guard < 3000) begin
      tick(); guard++;
      if (gate_en !== prefix(on)) begin
        check_eq("R1", "ramp-down order", gate_en, prefix(on - 1));
        if (first) begin
          check_eq(tag, "first gate-off latency", cyc - t0, lat_filt());
          check_eq("R5", "reset-done low on release", rst_done_n, 0);
          first = 1'b0;
        end else check_eq("R4", "step after low flag", cyc - ((on < 4) ? t_lo[on] : 0), 1);
        on--;
      end
    end
    while (gate_low !== 4'hF && guard < 3000) begin tick(); guard++; end
    repeat (2) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    int t0, t1, g;
    void'($urandom(32'd2718));
    repeat (5) tick();
    check_eq("R10", "gates in reset", gate_en, 0);
    check_eq("R10", "strobe in reset", fast_off, 0);
    check_eq("R10", "sys pull in reset", sys_rst_pull, 0);
    check_eq("R10", "done in reset", rst_done_n, 0);
    rst_n = 1'b1;

    uv_ok = 4'hF;
    repeat (40) tick();
    check_eq("R2", "no start without enable", gate_en, 0);

    en_n = 1'b0; repeat (FILT - 1) tick(); en_n = 1'b1;
    repeat (40) tick();
    check_eq("R9", "short enable pulse ignored", gate_en, 0);

    en_n = 1'b0; t0 = cyc;
    run_up(t0, lat_start());

    uv_ok[2] = 1'b0; repeat (FILT - 1) tick(); uv_ok[2] = 1'b1;
    repeat (FILT + 5) tick();
    check_eq("R9", "short uv dip gates", gate_en, 15);
    check_eq("R9", "short uv dip done", rst_done_n, 1);
    check_eq("R9", "short uv dip pull", sys_rst_pull, 0);

    en_n = 1'b1; t0 = cyc;
    run_down(t0, "R4");
    check_eq("R4", "pull after clean off", sys_rst_pull, 0);

    // rail lost during stabilisation wait
    en_n = 1'b0;
    repeat (FILT + STAB/2) tick();
    uv_ok[0] = 1'b0;
    repeat (FILT + 3) tick();
    check_eq("R2", "no fault during wait", sys_rst_pull, 0);
    check_eq("R2", "no gates during wait", gate_en, 0);
    uv_ok[0] = 1'b1; t1 = cyc;
    run_up(t1, lat_start());

    // under-voltage fault and automatic restart
    uv_ok[1] = 1'b0; t0 = cyc;
    wait_for(4'h0);
    check_eq("R6", "fault latency", cyc - t0, lat_filt());
    check_eq("R6", "strobe high", fast_off, 1);
    check_eq("R6", "sys pull high", sys_rst_pull, 1);
    check_eq("R6", "done low", rst_done_n, 0);
    tick();
    check_eq("R6", "strobe one cycle", fast_off, 0);
    repeat (30) tick();
    check_eq("R7", "pull held while rail missing", sys_rst_pull, 1);
    uv_ok[1] = 1'b1; t1 = cyc;
    g = 0;
    while (sys_rst_pull !== 1'b0 && g < 3000) begin tick(); g++; end
    check_eq("R7", "pull release latency", cyc - t1, lat_filt());
    run_up(t1, lat_restart());
    en_n = 1'b1; t0 = cyc;
    run_down(t0, "R4");

    // random handshake delays with short glitches
    for (int i = 0; i < 6; i++) begin
      int j, len;
      up_max = $urandom_range(30, 1);
      dn_max = $urandom_range(30, 1);
      en_n = 1'b0; t0 = cyc;
      run_up(t0, lat_start());
      j = $urandom_range(3, 0);
      len = $urandom_range(FILT - 1, 1);
      uv_ok[j] = 1'b0; repeat (len) tick(); uv_ok[j] = 1'b1;
      repeat (FILT + 5) tick();
      check_eq("R9", "random glitch ignored", gate_en, 15);
      en_n = 1'b1; t0 = cyc;
      run_down(t0, "R4");
    end
    up_max = 8; dn_max = 8;

    // power-up handshake timeout
    up_ok[1] = 1'b0;
    en_n = 1'b0;
    wait_for(4'h3); t1 = cyc;
    wait_for(4'h0);
    check_eq("R8", "up timeout latency", cyc - t1, TMO);
    check_eq("R8", "up timeout strobe", fast_off, 1);
    check_eq("R8", "up timeout pull", sys_rst_pull, 1);
    up_ok[1] = 1'b1;
    run_up(0, 0);

    // turn-off handshake timeout
    dn_ok[2] = 1'b0;
    en_n = 1'b1;
    wait_for(4'h3); t1 = cyc;
    wait_for(4'h0);
    check_eq("R8", "down timeout latency", cyc - t1, TMO);
    check_eq("R8", "down timeout strobe", fast_off, 1);
    check_eq("R8", "down timeout pull", sys_rst_pull, 1);
    dn_ok[2] = 1'b1;
    g = 0;
    while (sys_rst_pull !== 1'b0 && g < 3000) begin tick(); g++; end
    check_eq("R7", "pull clears when gates low", sys_rst_pull, 0);
    repeat (40) tick();
    check_eq("R7", "no restart without enable", gate_en, 0);

    // enable released mid power-up
    up_ok[2] = 1'b0;
    en_n = 1'b0;
    wait_for(4'h7);
    en_n = 1'b1; t0 = cyc;
    run_down(t0, "R11");
    up_ok[2] = 1'b1;
    check_eq("R11", "all off after partial ramp", gate_en, 0);

    summary();
  end
endmodule